// File: doc/BRIEF.md
# Per-Destination Cell Queue Input Buffer

This block is the input-side cell store of a switched backplane port. Arriving fixed-size cells, each tagged with the output it is bound for, go into one shared cell memory. Inside that memory the block keeps a separate linked FIFO for every output. A cell stuck behind a busy or flow-controlled output therefore never holds up cells bound for any other output. A stack of free slot indices supplies storage to every queue, so a single destination may take up the whole memory.

Toward the allocator the block raises one request bit per output. A bit is high when that output's queue holds a whole two-cell transfer that is not already being drained, and the output's inhibit line is low. When the allocator grants an output, the block sends that output's two oldest cells on the read port in the next two cycles and marks the second one as the last cell. When the memory is full, the write port deasserts ready and holds the sender off. It never discards a cell.

Top module: `vcq_input_buffer`

## Requirements
- R1: Every accepted cell is appended to the queue of its destination. Each queue delivers its cells in the order they were accepted.
- R2: Queues are independent. Cells waiting for one output do not delay or alter a transfer granted to another output.
- R3: `req[k]` is high exactly when queue k holds at least two cells not already committed to a grant and `inhibit[k]` is low. It follows `inhibit[k]` in the same cycle.
- R4: A grant is taken in cycle T when `gnt_valid` is high, no burst is running and `req[gnt_dest]` is high. The queue's two oldest cells then appear on `rd_cell` with `rd_valid` high in cycles T+1 and T+2, with `rd_dest` equal to the granted output. `rd_last` is 0 on the first cell and 1 on the second.
- R5: A grant is ignored when the request bit of its output is low (empty, one cell, or inhibited), or when it arrives in the cycle of a running burst's second cell. No cell is sent and that queue keeps its contents.
- R6: `wr_ready` is high when at least one slot is free and `wr_dest` is below NUM_DEST. A write offered while `wr_ready` is low is not stored.
- R7: Storage is shared. One queue can hold all DEPTH slots, and slots freed by reads are reused.
- R8: A write to a queue in the same cycle as a read from that queue keeps FIFO order. This holds even when the read removes the queue's last cell.
- R9: After reset all queues are empty, `req` is 0, `rd_valid` is 0 and `wr_ready` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_valid | input | 1 | A cell is offered on the write port |
| wr_ready | output | 1 | The offered cell is taken at this edge |
| wr_dest | input | DW | Destination output of the offered cell |
| wr_cell | input | CELL_W | Cell payload |
| inhibit | input | NUM_DEST | Per-output flow-control stop |
| req | output | NUM_DEST | Per-output transfer request to the allocator |
| gnt_valid | input | 1 | Allocator grant strobe |
| gnt_dest | input | DW | Output being granted |
| rd_valid | output | 1 | A cell is presented on the read port |
| rd_last | output | 1 | Second cell of the transfer |
| rd_dest | output | DW | Output that the presented cell belongs to |
| rd_cell | output | CELL_W | Cell payload being sent |

## Verification
The hardest cases to reach from the ports are the linked-list updates where a write and a read hit the same queue in the same cycle. The worst of these is a write landing in the cycle that removes the queue's only remaining cell, so the head must jump straight to the new slot. The bench gets there by loading a queue with exactly two cells, granting it, and driving the next write in the cycle of the burst's second cell. A companion case drives the write in the grant cycle itself. Filling the whole memory through one destination and draining it again exercises wrap-around reuse of the free slots.

// File: rtl/vcq_pkg.sv
package vcq_pkg;
   typedef enum logic {
      BURST_IDLE   = 1'b0,
      BURST_SECOND = 1'b1
   } burst_state_e;

   localparam int unsigned CELLS_PER_XFER = 2;
endpackage

// File: rtl/vcq_free_stack.sv
module vcq_free_stack #(
   parameter int unsigned DEPTH = 32,
   localparam int unsigned AW   = $clog2(DEPTH),
   localparam int unsigned CW   = $clog2(DEPTH + 1)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          take_en,
   output logic [AW-1:0] take_idx,
   input  logic          give_en,
   input  logic [AW-1:0] give_idx,
   output logic [CW-1:0] free_cnt
);
   logic [AW-1:0] slot_stk [DEPTH];
   logic [AW-1:0] top_idx;

   assign top_idx  = AW'(free_cnt - CW'(1));
   assign take_idx = slot_stk[top_idx];

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         free_cnt <= CW'(DEPTH);
         for (int i = 0; i < DEPTH; i++) slot_stk[i] <= AW'(i);
      end else if (take_en && give_en) begin
         slot_stk[top_idx] <= give_idx;
      end else if (give_en) begin
         slot_stk[AW'(free_cnt)] <= give_idx;
         free_cnt <= free_cnt + CW'(1);
      end else if (take_en) begin
         free_cnt <= free_cnt - CW'(1);
      end
   end

   a_r7_free_bound : assert property (@(posedge clk) disable iff (!rst_n)
      free_cnt <= CW'(DEPTH));
   a_r6_take_needs_slot : assert property (@(posedge clk) disable iff (!rst_n)
      take_en |-> free_cnt != '0);
endmodule

// File: rtl/vcq_dest_queue.sv
module vcq_dest_queue #(
   parameter int unsigned DEPTH = 32,
   localparam int unsigned AW   = $clog2(DEPTH),
   localparam int unsigned CW   = $clog2(DEPTH + 1)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          push,
   input  logic [AW-1:0] push_idx,
   input  logic          pop,
   input  logic [AW-1:0] head_link,
   output logic [AW-1:0] head,
   output logic [AW-1:0] tail,
   output logic [CW-1:0] cnt,
   output logic          link_need
);
   logic fresh_head;

   // Head goes straight to the new slot when the list is, or becomes, empty.
   assign fresh_head = (cnt == '0) || ((cnt == CW'(1)) && pop);
   assign link_need  = push && !fresh_head;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         head <= '0;
         tail <= '0;
         cnt  <= '0;
      end else begin
         cnt <= cnt + CW'(push) - CW'(pop);
         if (push) tail <= push_idx;
         if (push && fresh_head) head <= push_idx;
         else if (pop)           head <= head_link;
      end
   end

   a_r1_pop_nonempty : assert property (@(posedge clk) disable iff (!rst_n)
      pop |-> cnt != '0);
   a_r8_push_lands_tail : assert property (@(posedge clk) disable iff (!rst_n)
      push |=> tail == $past(push_idx));
endmodule

// File: rtl/vcq_burst_ctrl.sv
module vcq_burst_ctrl
   import vcq_pkg::*;
#(
   parameter int unsigned NUM_DEST = 15,
   localparam int unsigned DW      = $clog2(NUM_DEST)
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                gnt_valid,
   input  logic [DW-1:0]       gnt_dest,
   input  logic [NUM_DEST-1:0] req,
   output logic                pop_en,
   output logic [DW-1:0]       pop_dest,
   output logic                pop_second,
   output logic [NUM_DEST-1:0] draining
);
   burst_state_e  state;
   logic [DW-1:0] cur_dest;
   logic          accept;

   assign accept     = (state == BURST_IDLE) && gnt_valid &&
                       (gnt_dest < DW'(NUM_DEST)) && req[gnt_dest];
   assign pop_second = (state == BURST_SECOND);
   assign pop_en     = accept || pop_second;
   assign pop_dest   = pop_second ? cur_dest : gnt_dest;

   for (genvar k = 0; k < NUM_DEST; k++) begin : g_drain
      assign draining[k] = pop_second && (cur_dest == DW'(k));
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state    <= BURST_IDLE;
         cur_dest <= '0;
      end else begin
         state <= accept ? BURST_SECOND : BURST_IDLE;
         if (accept) cur_dest <= gnt_dest;
      end
   end

   a_r4_second_follows : assert property (@(posedge clk) disable iff (!rst_n)
      accept |=> pop_en && pop_second && pop_dest == $past(gnt_dest));
   a_r5_no_grant_midburst : assert property (@(posedge clk) disable iff (!rst_n)
      pop_second |=> !pop_second);
endmodule

// File: rtl/vcq_input_buffer.sv
module vcq_input_buffer
   import vcq_pkg::*;
#(
   parameter int unsigned NUM_DEST = 15,
   parameter int unsigned DEPTH    = 32,
   parameter int unsigned CELL_W   = 64,
   localparam int unsigned DW      = $clog2(NUM_DEST),
   localparam int unsigned AW      = $clog2(DEPTH),
   localparam int unsigned CW      = $clog2(DEPTH + 1)
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                wr_valid,
   output logic                wr_ready,
   input  logic [DW-1:0]       wr_dest,
   input  logic [CELL_W-1:0]   wr_cell,
   input  logic [NUM_DEST-1:0] inhibit,
   output logic [NUM_DEST-1:0] req,
   input  logic                gnt_valid,
   input  logic [DW-1:0]       gnt_dest,
   output logic                rd_valid,
   output logic                rd_last,
   output logic [DW-1:0]       rd_dest,
   output logic [CELL_W-1:0]   rd_cell
);
   initial begin
      if (NUM_DEST < 2) $fatal(1, "NUM_DEST must be at least 2");
      if (DEPTH < CELLS_PER_XFER || (DEPTH & (DEPTH - 1)) != 0)
         $fatal(1, "DEPTH must be a power of two of at least 2");
      if (CELL_W < 1) $fatal(1, "CELL_W must be positive");
   end

   logic [CELL_W-1:0]   cell_mem [DEPTH];
   logic [AW-1:0]       link_mem [DEPTH];

   logic [AW-1:0]       q_head [NUM_DEST];
   logic [AW-1:0]       q_tail [NUM_DEST];
   logic [CW-1:0]       q_cnt  [NUM_DEST];
   logic [NUM_DEST-1:0] q_link_need;
   logic [NUM_DEST-1:0] draining;

   logic [CW-1:0]       free_cnt;
   logic [AW-1:0]       alloc_idx;
   logic                wr_acc;
   logic                pop_en;
   logic                pop_second;
   logic [DW-1:0]       pop_dest;
   logic [AW-1:0]       pop_slot;

   assign wr_ready = (free_cnt != '0) && (wr_dest < DW'(NUM_DEST));
   assign wr_acc   = wr_valid && wr_ready;
   assign pop_slot = q_head[pop_dest];

   vcq_free_stack #(.DEPTH(DEPTH)) u_free (
      .clk      (clk),
      .rst_n    (rst_n),
      .take_en  (wr_acc),
      .take_idx (alloc_idx),
      .give_en  (pop_en),
      .give_idx (pop_slot),
      .free_cnt (free_cnt)
   );

   vcq_burst_ctrl #(.NUM_DEST(NUM_DEST)) u_burst (
      .clk        (clk),
      .rst_n      (rst_n),
      .gnt_valid  (gnt_valid),
      .gnt_dest   (gnt_dest),
      .req        (req),
      .pop_en     (pop_en),
      .pop_dest   (pop_dest),
      .pop_second (pop_second),
      .draining   (draining)
   );

   for (genvar k = 0; k < NUM_DEST; k++) begin : g_q
      logic [CW-1:0] avail;

      vcq_dest_queue #(.DEPTH(DEPTH)) u_q (
         .clk       (clk),
         .rst_n     (rst_n),
         .push      (wr_acc && (wr_dest == DW'(k))),
         .push_idx  (alloc_idx),
         .pop       (pop_en && (pop_dest == DW'(k))),
         .head_link (link_mem[q_head[k]]),
         .head      (q_head[k]),
         .tail      (q_tail[k]),
         .cnt       (q_cnt[k]),
         .link_need (q_link_need[k])
      );

      // A cell already committed to the running burst is not offered again.
      assign avail  = q_cnt[k] - CW'(draining[k]);
      assign req[k] = (avail >= CW'(CELLS_PER_XFER)) && !inhibit[k];
   end

   always_ff @(posedge clk) begin
      if (wr_acc) cell_mem[alloc_idx] <= wr_cell;
      if (|q_link_need) link_mem[q_tail[wr_dest]] <= alloc_idx;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         rd_valid <= 1'b0;
         rd_last  <= 1'b0;
         rd_dest  <= '0;
         rd_cell  <= '0;
      end else begin
         rd_valid <= pop_en;
         rd_last  <= pop_en && pop_second;
         if (pop_en) begin
            rd_dest <= pop_dest;
            rd_cell <= cell_mem[pop_slot];
         end
      end
   end

   int unsigned held_total;
   always_comb begin
      held_total = 32'(free_cnt);
      for (int k = 0; k < NUM_DEST; k++) held_total += 32'(q_cnt[k]);
   end

   a_r7_slot_conservation : assert property (@(posedge clk) disable iff (!rst_n)
      held_total == DEPTH);
   a_r4_beat_pair : assert property (@(posedge clk) disable iff (!rst_n)
      rd_valid && !rd_last |=> rd_valid && rd_last && rd_dest == $past(rd_dest));
   a_r4_last_has_first : assert property (@(posedge clk) disable iff (!rst_n)
      rd_last |-> rd_valid);
   a_r6_full_blocks : assert property (@(posedge clk) disable iff (!rst_n)
      free_cnt == '0 |-> !wr_ready);
endmodule

// File: tb/vcq_input_buffer_bench.sv
module vcq_input_buffer_bench;
   localparam int CLK_PERIOD = 10;
   localparam int N  = 15;
   localparam int D  = 32;
   localparam int CW = 64;
   localparam int DW = $clog2(N);

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          wr_valid = 1'b0;
   logic          wr_ready;
   logic [DW-1:0] wr_dest = '0;
   logic [CW-1:0] wr_cell = '0;
   logic [N-1:0]  inhibit = '0;
   logic [N-1:0]  req;
   logic          gnt_valid = 1'b0;
   logic [DW-1:0] gnt_dest = '0;
   logic          rd_valid;
   logic          rd_last;
   logic [DW-1:0] rd_dest;
   logic [CW-1:0] rd_cell;

   int total = 0;
   int bad   = 0;
   logic [CW-1:0] expq [N][$];

   always #(CLK_PERIOD / 2) clk = ~clk;

   vcq_input_buffer #(.NUM_DEST(N), .DEPTH(D), .CELL_W(CW)) u_vcq_input_buffer (
      .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .wr_ready(wr_ready),
      .wr_dest(wr_dest), .wr_cell(wr_cell), .inhibit(inhibit), .req(req),
      .gnt_valid(gnt_valid), .gnt_dest(gnt_dest), .rd_valid(rd_valid),
      .rd_last(rd_last), .rd_dest(rd_dest), .rd_cell(rd_cell)
   );

   task automatic chk(input bit ok, input string tag, input logic [63:0] act,
                      input logic [63:0] exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   function automatic logic [CW-1:0] mk(input int d, input int s);
      return {16'hCE11, 16'(d), 32'(s)};
   endfunction

   // Offer one cell for a single cycle; queue it in the model if accepted.
   task automatic push(input int d, input logic [CW-1:0] data, output bit acc);
      @(negedge clk);
      wr_valid = 1'b1; wr_dest = DW'(d); wr_cell = data;
      #1 acc = wr_ready;
      @(posedge clk);
      #1 wr_valid = 1'b0;
      if (acc) expq[d].push_back(data);
   endtask

   task automatic load(input int d, input int n, input int base);
      bit acc;
      for (int i = 0; i < n; i++) begin
         push(d, mk(d, base + i), acc);
         chk(acc, "R6 write accepted with free slots", 64'(acc), 64'd1);
      end
   endtask

   task automatic beat(input int d, input bit last, input string tag);
      logic [CW-1:0] e;
      e = expq[d].pop_front();
      chk(rd_valid === 1'b1, {tag, " rd_valid"}, 64'(rd_valid), 64'd1);
      chk(rd_last === last, {tag, " rd_last"}, 64'(rd_last), 64'(last));
      chk(rd_dest === DW'(d), {tag, " rd_dest"}, 64'(rd_dest), 64'(d));
      chk(rd_cell === e, {tag, " rd_cell order"}, rd_cell, e);
   endtask

   task automatic grant(input int d, input string tag);
      @(negedge clk);
      gnt_valid = 1'b1; gnt_dest = DW'(d);
      @(posedge clk);
      #1 gnt_valid = 1'b0;
      @(negedge clk); beat(d, 1'b0, tag);
      @(negedge clk); beat(d, 1'b1, tag);
   endtask

   task automatic expect_idle(input string tag);
      @(negedge clk);
      chk(rd_valid === 1'b0, tag, 64'(rd_valid), 64'd0);
   endtask

   task automatic t_reset;
      @(negedge clk);
      chk(wr_ready === 1'b1, "R9 wr_ready after reset", 64'(wr_ready), 64'd1);
      chk(req === '0, "R9 req after reset", 64'(req), 64'd0);
      chk(rd_valid === 1'b0, "R9 rd_valid after reset", 64'(rd_valid), 64'd0);
   endtask

   task automatic t_request_rule;
      load(3, 1, 0);
      #1 chk(req[3] === 1'b0, "R3 one cell gives no request", 64'(req[3]), 64'd0);
      load(3, 1, 1);
      #1 chk(req[3] === 1'b1, "R3 two cells raise request", 64'(req[3]), 64'd1);
      @(negedge clk); inhibit[3] = 1'b1;
      #1 chk(req[3] === 1'b0, "R3 inhibit masks request", 64'(req[3]), 64'd0);
      @(negedge clk);
      gnt_valid = 1'b1; gnt_dest = 4'd3;
      @(posedge clk);
      #1 gnt_valid = 1'b0;
      expect_idle("R5 grant to inhibited output ignored");
      expect_idle("R5 grant to inhibited output ignored, second cycle");
      inhibit[3] = 1'b0;
      #1 chk(req[3] === 1'b1, "R5 queue kept after ignored grant", 64'(req[3]), 64'd1);
      grant(3, "R4 basic transfer");
      #1 chk(req[3] === 1'b0, "R4 request clears after drain", 64'(req[3]), 64'd0);
      expect_idle("R4 no third cell");
   endtask

   task automatic t_independent;
      load(0, 1, 10); load(14, 1, 20); load(0, 1, 11); load(14, 1, 21);
      load(0, 1, 12);
      @(negedge clk); inhibit[0] = 1'b1;
      grant(14, "R2 output 14 past blocked output 0");
      inhibit[0] = 1'b0;
      grant(0, "R1 interleaved queue 0 order");
      chk(expq[0].size() == 1, "R1 leftover in queue 0", 64'(expq[0].size()), 64'd1);
      #1 chk(req[0] === 1'b0, "R3 single leftover no request", 64'(req[0]), 64'd0);
      load(0, 1, 13);
      grant(0, "R1 leftover then new cell");
   endtask

   task automatic t_grant_rules;
      @(negedge clk);
      gnt_valid = 1'b1; gnt_dest = 4'd6;
      @(posedge clk);
      #1 gnt_valid = 1'b0;
      expect_idle("R5 grant to empty queue ignored");
      load(2, 2, 30); load(7, 2, 40);
      @(negedge clk);
      gnt_valid = 1'b1; gnt_dest = 4'd2;
      @(negedge clk);
      beat(2, 1'b0, "R4 first of burst");
      gnt_dest = 4'd7;
      @(negedge clk);
      gnt_valid = 1'b0;
      beat(2, 1'b1, "R4 second of burst");
      expect_idle("R5 mid-burst grant ignored");
      #1 chk(req[7] === 1'b1, "R5 mid-burst grant left queue 7", 64'(req[7]), 64'd1);
      grant(7, "R2 later grant to queue 7");
   endtask

   task automatic t_back_to_back;
      load(4, 4, 50);
      @(negedge clk);
      gnt_valid = 1'b1; gnt_dest = 4'd4;
      @(negedge clk);
      beat(4, 1'b0, "R4 continuous first");
      chk(req[4] === 1'b1, "R3 remaining pair requested during burst", 64'(req[4]), 64'd1);
      gnt_valid = 1'b0;
      @(negedge clk);
      beat(4, 1'b1, "R4 continuous second");
      gnt_valid = 1'b1;
      @(negedge clk);
      gnt_valid = 1'b0;
      beat(4, 1'b0, "R4 continuous third");
      @(negedge clk);
      beat(4, 1'b1, "R4 continuous fourth");
   endtask

   task automatic t_same_cycle;
      bit acc;
      load(9, 2, 60);
      // write in the grant cycle
      @(negedge clk);
      gnt_valid = 1'b1; gnt_dest = 4'd9;
      wr_valid = 1'b1; wr_dest = 4'd9; wr_cell = mk(9, 62);
      @(posedge clk);
      #1 gnt_valid = 1'b0; wr_valid = 1'b0;
      expq[9].push_back(mk(9, 62));
      @(negedge clk); beat(9, 1'b0, "R8 write with grant");
      @(negedge clk); beat(9, 1'b1, "R8 write with grant");
      load(9, 1, 63);
      grant(9, "R8 order after write with grant");
      // write in the cycle that removes the last cell
      load(9, 2, 64);
      @(negedge clk);
      gnt_valid = 1'b1; gnt_dest = 4'd9;
      @(negedge clk);
      gnt_valid = 1'b0;
      beat(9, 1'b0, "R8 last-cell pop with write");
      wr_valid = 1'b1; wr_dest = 4'd9; wr_cell = mk(9, 66);
      #1 acc = wr_ready;
      @(negedge clk);
      wr_valid = 1'b0;
      beat(9, 1'b1, "R8 last-cell pop with write");
      if (acc) expq[9].push_back(mk(9, 66));
      chk(acc, "R6 write accepted during pop", 64'(acc), 64'd1);
      load(9, 1, 67);
      grant(9, "R8 head moved to new cell");
   endtask

   task automatic t_fill;
      bit acc;
      load(5, D, 100);
      @(negedge clk);
      chk(wr_ready === 1'b0, "R6 wr_ready low when full", 64'(wr_ready), 64'd0);
      push(5, mk(5, 999), acc);
      chk(!acc, "R6 write refused when full", 64'(acc), 64'd0);
      for (int b = 0; b < D / 2; b++) begin
         grant(5, "R7 drain of full memory");
         if (b == 0) begin
            #1 chk(wr_ready === 1'b1, "R7 freed slots reopen write", 64'(wr_ready), 64'd1);
         end
      end
      #1 chk(req[5] === 1'b0, "R6 refused cell not stored", 64'(req[5]), 64'd0);
      expect_idle("R6 nothing extra after drain");
      load(5, 2, 200);
      grant(5, "R7 reuse of freed slots");
   endtask

   initial begin
      repeat (3) @(posedge clk);
      #1 rst_n = 1'b1;
      t_reset();
      t_request_rule();
      t_independent();
      t_grant_rules();
      t_back_to_back();
      t_same_cycle();
      t_fill();
      repeat (2) @(negedge clk);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      total++;
      bad++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule